// File: doc/BRIEF.md
# Circular Return-Address Stack

This block stores return addresses for a small processor core. The core pushes a 13-bit program-counter value when it takes a subroutine call or an interrupt branch. It pops the stack on any of its three return-type instructions. The entry on top of the stack is always visible on a combinational output, so the program counter can load it in the same cycle as the pop.

There are eight entries, and the pointer is a hidden counter that wraps modulo the depth. There is no overflow or underflow flag. A ninth push without an intervening pop overwrites the oldest entry, and a pop past empty moves the pointer round to the far end. Push and pop are single-cycle control strobes rather than a handshake, because the core never has to wait on the stack. Reset clears only the pointer; the stored values are not defined after reset.

Top module: `ret_addr_stack`

## Requirements
- R1: A push in cycle N writes `push_pc_i` into the entry at the pointer, and `tos_o` shows that value from cycle N+1 on.
- R2: `tos_o` always shows the entry just below the pointer, without a clock. After a pop with no push in the same cycle, it shows the value that was pushed before the popped one.
- R3: Up to eight pushed values come back in reverse order of pushing through successive pops.
- R4: Pushes wrap round the eight entries. A ninth push overwrites the first stored value, a tenth push overwrites the second, and so on, and no error is signalled.
- R5: A pop with the pointer at entry 0 moves it to entry 7, so `tos_o` then shows entry 6. No error is signalled.
- R6: When push and pop are both high in one cycle, the push is performed and the pop is ignored.
- R7: Reset, active low and asynchronous, returns the pointer to entry 0. The first push after reset is then shown on `tos_o`.
- R8: With neither push nor pop asserted, the pointer and `tos_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push strobe (call or interrupt branch) |
| push_pc_i | input | 13 | Return address to store |
| pop_i | input | 1 | Pop strobe (any return instruction) |
| tos_o | output | 13 | Current top-of-stack entry |

## Verification
The bench goes after the wrap points. It runs ten pushes in a row to test overwriting the oldest entry. A design that counted to nine, or that saturated, would return the wrong value on the eighth pop. It pops at entry 0 to test the pointer wrapping downward; a design that clamped at zero would keep showing the bottom entry. It also asserts push and pop together to check the priority, which a design that gave pop priority, or did both, would fail by losing the pushed address. A registered top-of-stack output would show up one cycle late at every comparison.

// File: rtl/ras_pkg.sv
package ras_pkg;
  localparam int unsigned RAS_DEPTH_DEF  = 8;
  localparam int unsigned RAS_ADDR_W_DEF = 13;

  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_UP   = 2'd1,
    PTR_DOWN = 2'd2
  } ptr_op_e;
endpackage

// File: rtl/ras_ptr.sv
module ras_ptr
  import ras_pkg::*;
#(
  parameter int unsigned DEPTH = RAS_DEPTH_DEF,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ptr_op_e       op_i,
  output logic [PW-1:0] ptr_o,
  output logic [PW-1:0] rd_idx_o
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] ptr_q, ptr_inc, ptr_dec;

  assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + PW'(1);
  assign ptr_dec = (ptr_q == '0) ? LAST : ptr_q - PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else begin
      case (op_i)
        PTR_UP:   ptr_q <= ptr_inc;
        PTR_DOWN: ptr_q <= ptr_dec;
        default:  ptr_q <= ptr_q;
      endcase
    end
  end

  assign ptr_o    = ptr_q;
  assign rd_idx_o = ptr_dec;
endmodule

// File: rtl/ras_regs.sv
module ras_regs #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 13,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PW-1:0]     wr_idx_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic [PW-1:0]     rd_idx_i,
  output logic [ADDR_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (we_i && (wr_idx_i == PW'(g))) begin
        slot_q[g] <= wdata_i;
      end
    end
  end

  assign rdata_o = slot_q[rd_idx_i];
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int unsigned DEPTH  = RAS_DEPTH_DEF,
  parameter int unsigned ADDR_W = RAS_ADDR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_pc_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] tos_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ptr_op_e       op;
  logic [PW-1:0] ptr_q, rd_idx;

  // Push wins over a simultaneous pop (R6).
  always_comb begin
    if (push_i)     op = PTR_UP;
    else if (pop_i) op = PTR_DOWN;
    else            op = PTR_HOLD;
  end

  ras_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .ptr_o    (ptr_q),
    .rd_idx_o (rd_idx)
  );

  ras_regs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .we_i     (push_i),
    .wr_idx_i (ptr_q),
    .wdata_i  (push_pc_i),
    .rd_idx_i (rd_idx),
    .rdata_o  (tos_o)
  );
endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 13,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic [ADDR_W-1:0] push_pc_i,
  input logic              pop_i,
  input logic [ADDR_W-1:0] tos_o,
  input logic [PW-1:0]     ptr_i
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction
  function automatic logic [PW-1:0] prv(input logic [PW-1:0] p);
    return (p == '0) ? LAST : p - PW'(1);
  endfunction

  AST_PUSH_SHOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> tos_o == $past(push_pc_i)); // R1
  AST_PUSH_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> ptr_i == nxt($past(ptr_i))); // R4
  AST_POP_RETREAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> ptr_i == prv($past(ptr_i))); // R5
  AST_PUSH_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> ptr_i == nxt($past(ptr_i))); // R6
  AST_RESET_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> ptr_i == '0); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> ($stable(ptr_i) && $stable(tos_o))); // R8
endmodule

bind ret_addr_stack ras_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .push_i    (push_i),
  .push_pc_i (push_pc_i),
  .pop_i     (pop_i),
  .tos_o     (tos_o),
  .ptr_i     (ptr_q)
);

// File: tb/ret_addr_stack_bench.sv
module ret_addr_stack_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0;
  logic [12:0] push_pc_i = '0;
  logic        pop_i = 1'b0;
  logic [12:0] tos_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_val [DEPTH];
  bit m_vld [DEPTH];
  int m_ptr = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ret_addr_stack u_ret_addr_stack (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i),
    .push_pc_i(push_pc_i), .pop_i(pop_i), .tos_o(tos_o)
  );

  // Compare the top of stack with the model whenever the model knows it.
  task automatic check_top(input string tag);
    int idx;
    idx = (m_ptr + DEPTH - 1) % DEPTH;
    if (m_vld[idx]) begin
      checks++;
      if (int'(tos_o) != m_val[idx]) begin
        errors++;
        $display("FAIL %s tos_o=%h expected=%h", tag, tos_o, m_val[idx][12:0]);
      end
    end
  endtask

  task automatic model_reset();
    m_ptr = 0;
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
  endtask

  task automatic cyc(input bit p, input bit q, input int v, input string tag);
    @(negedge clk_i);
    check_top(tag);
    push_i = p; pop_i = q; push_pc_i = v[12:0];
    #1 check_top(tag);          // combinational output unchanged before the edge (R2)
    @(posedge clk_i);
    if (p) begin
      m_val[m_ptr] = v & 32'h1FFF; m_vld[m_ptr] = 1; m_ptr = (m_ptr + 1) % DEPTH;
    end else if (q) begin
      m_ptr = (m_ptr + DEPTH - 1) % DEPTH;
    end
    #1 push_i = 0; pop_i = 0;
    @(negedge clk_i);
    check_top(tag);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
  endtask

  initial begin
    model_reset();
    do_reset();
    // R7: first push after reset lands on top
    cyc(1, 0, 13'h1ABC, "R7");
    // R1: varied data patterns
    cyc(1, 0, 13'h0000, "R1");
    cyc(1, 0, 13'h1FFF, "R1");
    cyc(1, 0, 13'h0AAA, "R1");
    cyc(1, 0, 13'h1555, "R1");
    // R2: pops expose earlier values
    cyc(0, 1, 0, "R2");
    cyc(0, 1, 0, "R2");
    // R8: idle cycles hold
    cyc(0, 0, 13'h1234, "R8");
    cyc(0, 0, 13'h0F0F, "R8");
    // R3: full LIFO sequence
    do_reset();
    for (int i = 0; i < 8; i++) cyc(1, 0, 13'h0100 + i * 13'h0011, "R3");
    for (int i = 0; i < 7; i++) cyc(0, 1, 0, "R3");
    // R4: ten pushes overwrite the two oldest
    do_reset();
    for (int i = 0; i < 10; i++) cyc(1, 0, 13'h0800 + i * 13'h0101, "R4");
    for (int i = 0; i < 9; i++) cyc(0, 1, 0, "R4");
    // R5: pop past empty wraps (all entries now known)
    do_reset();
    for (int i = 0; i < 8; i++) cyc(1, 0, 13'h1000 + i * 13'h0023, "R5");
    cyc(0, 1, 0, "R5");
    cyc(0, 1, 0, "R5");
    cyc(1, 0, 13'h0777, "R5");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R5");
    // R6: simultaneous push and pop
    cyc(1, 1, 13'h1357, "R6");
    cyc(1, 1, 13'h0246, "R6");
    cyc(0, 1, 0, "R6");
    cyc(0, 1, 0, "R6");
    // R7: reset in mid-use
    do_reset();
    cyc(1, 0, 13'h0C3C, "R7");
    cyc(1, 0, 13'h13C3, "R7");
    cyc(0, 1, 0, "R7");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule